// File: doc/BRIEF.md
# Locality Ownership Lock Arbiter

This block decides which of five privilege levels ("localities", numbered 0 to 4) may drive a shared security coprocessor at any moment. Software at each level reaches its own byte-wide access register through a register window. The windows are spaced one 4 KB page apart, so the page number in the address names the locality being written or read. At most one locality owns the lock at a time. The others may leave a standing request that is honoured when the lock comes free, and the highest-numbered waiting locality is served first.

A locality that owns the lock keeps it until it gives it up. The one exception is a seize: a strictly higher locality can take the lock from a lower owner that has stalled. Locality 4 is reserved for the platform hardware, so its register accepts writes only while a qualifier input marks the current bus cycle as one that software cannot produce. The block reports the owner as an index plus a valid flag and as a one-hot vector. It also reports a per-window read value and a single-cycle pulse whenever ownership moves.

Top module: `locality_lock_arbiter`

## Requirements
- R1: After reset no locality owns the lock: `owner_valid` is 0, `owner_idx` is 0, `owner_onehot` is 0, no request is pending and `loc_changed` is 0. `owner_idx` also reads 0 whenever `owner_valid` is 0.
- R2: A write reaches locality L's access register only when `addr[14:12]` equals L with L in 0..4 and `addr[11:0]` is zero; `addr[15]` is not decoded. Writes to pages 5 to 7 or to any other offset change nothing, and reads there return 0x00.
- R3: Writing a value with bit 1 set (0x02) marks the locality pending at that clock edge. If the lock is free at the following edge, the highest pending locality becomes owner at that edge.
- R4: While a locality owns the lock, requests from other localities stay pending and no handover occurs. A request written by the current owner is ignored.
- R5: A write with bit 5 set (0x20) by the owner frees the lock at that edge. Any grant happens no earlier than the next edge.
- R6: When the lock is free and several localities are pending, the one with the highest number is granted, and its pending bit clears.
- R7: A bit-5 write from a locality that does not own the lock withdraws its pending request. A locality withdrawn at the same edge as a grant is excluded from that grant.
- R8: A write with bit 3 set (0x08) from a locality numbered higher than the current owner takes the lock at that edge and clears its own pending bit. From an equal or lower locality, or when no locality owns the lock, it has no effect. Within one written byte, bit 5 overrides bit 3, and bit 3 overrides bit 1.
- R9: Writes to locality 4's register take effect only while `hw_cycle` is 1. Without it they change nothing.
- R10: Reading a valid window returns bit 7 = 1, bit 5 = 1 only when that locality owns the lock, bit 1 = 1 when it is pending, and all other bits 0. `owner_onehot` has bit L set only while L owns the lock.
- R11: `loc_changed` is high for exactly the cycles in which `owner_valid` or the valid owner's index differs from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 16 | Register-window byte address |
| wdata | input | 8 | Write data byte |
| hw_cycle | input | 1 | Qualifier marking a hardware-only bus cycle |
| rdata | output | 8 | Combinational read value of the addressed access register |
| owner_idx | output | 3 | Index of the current owner |
| owner_valid | output | 1 | A locality currently owns the lock |
| owner_onehot | output | 5 | One bit per locality, set for the owner |
| loc_changed | output | 1 | One-cycle pulse on any change of ownership |

## Verification
The bench targets four corner cases:
- **Handover edge after a release.** A design that grants in the same cycle as the release would skip the cycle in which no locality owns the lock.
- **A withdrawal landing on the grant edge.** Arbitrating on stale pending bits would hand the lock to a locality that had just withdrawn.
- **Downward or sideways seizes, and seizes with no owner.** A careless comparison would let a lower or equal locality take the lock, or let a seize create an owner from nothing.
- **Locality 4 writes without the qualifier, and addresses that alias a window.** A wrong decode would let software reach the hardware-only locality, or let a non-zero offset touch the lock.

A long pseudo-random run then mixes all write kinds against the reference model, so that priority ties and bit-precedence errors show up as mismatches in the owner or read value.

// File: rtl/locality_lock_arbiter.sv
module locality_lock_arbiter #(
  parameter int NUM_LOC  = 5,
  parameter int ADDR_W   = 16,
  parameter int PAGE_LSB = 12,
  parameter int IDX_W    = $clog2(NUM_LOC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         wdata,
  input  logic               hw_cycle,
  output logic [7:0]         rdata,
  output logic [IDX_W-1:0]   owner_idx,
  output logic               owner_valid,
  output logic [NUM_LOC-1:0] owner_onehot,
  output logic               loc_changed
);

  localparam int BIT_REQ   = 1;
  localparam int BIT_SEIZE = 3;
  localparam int BIT_REL   = 5;
  localparam logic [IDX_W-1:0] TOP_LOC = IDX_W'(NUM_LOC - 1);

  logic [IDX_W-1:0]   own_q, own_d, pick;
  logic               vld_q, vld_d, found, chg_q;
  logic [NUM_LOC-1:0] pend_q, pend_d, cand, sel_mask;

  wire [IDX_W-1:0] sel    = addr[PAGE_LSB +: IDX_W];
  wire             in_win = (sel <= TOP_LOC) && (addr[PAGE_LSB-1:0] == '0);
  wire             wr_hit = wr_en && in_win && (sel != TOP_LOC || hw_cycle);
  wire             is_own = vld_q && (own_q == sel);

  wire rel_hit = wr_hit && wdata[BIT_REL];
  wire sz_hit  = wr_hit && !wdata[BIT_REL] && wdata[BIT_SEIZE] && vld_q && (sel > own_q);
  wire rq_hit  = wr_hit && !wdata[BIT_REL] && !wdata[BIT_SEIZE] && wdata[BIT_REQ] && !is_own;

  assign sel_mask = NUM_LOC'(1) << sel;
  assign cand     = pend_q & ~(rel_hit ? sel_mask : '0);

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (cand[i]) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    own_d  = own_q;
    vld_d  = vld_q;
    pend_d = cand | (rq_hit ? sel_mask : '0);
    if (rel_hit && is_own) begin
      vld_d = 1'b0;
      own_d = '0;
    end else if (sz_hit) begin
      own_d  = sel;
      vld_d  = 1'b1;
      pend_d = pend_d & ~sel_mask;
    end else if (!vld_q && found) begin
      own_d        = pick;
      vld_d        = 1'b1;
      pend_d[pick] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '0;
      vld_q  <= 1'b0;
      pend_q <= '0;
      chg_q  <= 1'b0;
    end else begin
      own_q  <= own_d;
      vld_q  <= vld_d;
      pend_q <= pend_d;
      chg_q  <= (vld_d != vld_q) || (vld_d && own_d != own_q);
    end
  end

  assign owner_idx    = own_q;
  assign owner_valid  = vld_q;
  assign owner_onehot = vld_q ? (NUM_LOC'(1) << own_q) : '0;
  assign loc_changed  = chg_q;
  assign rdata = in_win ? {1'b1, 1'b0, is_own, 3'b000, pend_q[sel], 1'b0} : 8'h00;

endmodule

module locality_lock_arbiter_props #(
  parameter int NUM_LOC  = 5,
  parameter int ADDR_W   = 16,
  parameter int PAGE_LSB = 12,
  parameter int IDX_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic               hw_cycle,
  input logic [IDX_W-1:0]   owner_idx,
  input logic               owner_valid,
  input logic [NUM_LOC-1:0] owner_onehot,
  input logic               loc_changed
);

  localparam logic [IDX_W-1:0] TOP_LOC = IDX_W'(NUM_LOC - 1);

  wire top_sw_wr = wr_en && (addr[PAGE_LSB +: IDX_W] == TOP_LOC) &&
                   (addr[PAGE_LSB-1:0] == '0) && !hw_cycle;

  assert_owner_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner_onehot) && (owner_valid == (owner_onehot != '0)));

  assert_change_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_valid != $past(owner_valid) || (owner_valid && owner_idx != $past(owner_idx)))
      |-> loc_changed);

  assert_pulse_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    loc_changed |->
      (owner_valid != $past(owner_valid) || (owner_valid && owner_idx != $past(owner_idx))));

  assert_seize_upward_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_valid && $past(owner_valid) && owner_idx != $past(owner_idx))
      |-> owner_idx > $past(owner_idx));

  assert_top_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (top_sw_wr && owner_valid && owner_idx == TOP_LOC)
      |=> (owner_valid && owner_idx == TOP_LOC));

endmodule

bind locality_lock_arbiter locality_lock_arbiter_props #(
  .NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .IDX_W(IDX_W)
) u_props (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .hw_cycle(hw_cycle),
  .owner_idx(owner_idx), .owner_valid(owner_valid),
  .owner_onehot(owner_onehot), .loc_changed(loc_changed)
);

// File: tb/locality_lock_arbiter_bench.sv
module locality_lock_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        hw_cycle = 1'b0;
  logic [7:0]  rdata;
  logic [2:0]  owner_idx;
  logic        owner_valid;
  logic [4:0]  owner_onehot;
  logic        loc_changed;

  always #5 clk = ~clk;

  locality_lock_arbiter u_locality_lock_arbiter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .hw_cycle(hw_cycle), .rdata(rdata), .owner_idx(owner_idx),
    .owner_valid(owner_valid), .owner_onehot(owner_onehot), .loc_changed(loc_changed)
  );

  localparam logic [7:0] REQ = 8'h02, SZ = 8'h08, REL = 8'h20;

  int n_cmp = 0, n_bad = 0;
  int m_own = -1;
  bit m_pend[5];
  bit m_chg = 1'b0;

  function automatic logic [15:0] win(int l);
    return 16'(l << 12);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int sel;
    bit ok;
    int exp_rd;
    sel = int'(addr[14:12]);
    ok  = (sel < 5) && (addr[11:0] == 12'h000);
    exp_rd = 0;
    if (ok) exp_rd = 8'h80 | ((m_own == sel) ? 8'h20 : 0) | (m_pend[sel] ? 8'h02 : 0);
    check($sformatf("%s valid", tag), int'(owner_valid), (m_own >= 0) ? 1 : 0);
    check($sformatf("%s idx", tag), int'(owner_idx), (m_own >= 0) ? m_own : 0);
    check($sformatf("%s onehot R10", tag), int'(owner_onehot), (m_own >= 0) ? (1 << m_own) : 0);
    check($sformatf("%s pulse R11", tag), int'(loc_changed), int'(m_chg));
    check($sformatf("%s rdata R10", tag), int'(rdata), exp_rd);
  endtask

  task automatic model_step();
    int sel, old, clr, setl, winner;
    bit hit, rel, sz;
    sel = int'(addr[14:12]);
    hit = wr_en && sel < 5 && addr[11:0] == 12'h000 && (sel != 4 || hw_cycle);
    old = m_own; clr = -1; setl = -1; winner = -1; rel = 0; sz = 0;
    if (hit) begin
      if (wdata[5]) begin
        clr = sel;
        if (m_own == sel) rel = 1;
      end else if (wdata[3]) begin
        if (m_own >= 0 && sel > m_own) sz = 1;
      end else if (wdata[1] && m_own != sel) begin
        setl = sel;
      end
    end
    if (clr >= 0) m_pend[clr] = 0;
    if (rel) m_own = -1;
    else if (sz) m_own = sel;
    else if (m_own < 0) begin
      for (int i = 4; i >= 0; i--) begin
        if (m_pend[i] && winner < 0) winner = i;
      end
      if (winner >= 0) m_own = winner;
    end
    if (setl >= 0) m_pend[setl] = 1;
    if (sz) m_pend[sel] = 0;
    if (winner >= 0) m_pend[winner] = 0;
    m_chg = (m_own != old);
  endtask

  task automatic cyc(logic w, logic [15:0] a, logic [7:0] d, logic h, string tag);
    wr_en = w; addr = a; wdata = d; hw_cycle = h;
    @(posedge clk);
    model_step();
    #1 compare(tag);
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned lfsr;
    logic [7:0] pat [6];
    pat[0] = REQ; pat[1] = SZ; pat[2] = REL; pat[3] = REQ | SZ; pat[4] = 8'h00; pat[5] = 8'hFF;
    for (int i = 0; i < 5; i++) m_pend[i] = 0;
    repeat (3) @(posedge clk);
    #1 compare("R1 reset");
    rst_n = 1'b1;
    cyc(0, win(0), 0, 0, "R1 idle");

    cyc(1, win(0), REQ, 0, "R3 request");
    cyc(0, win(0), 0, 0, "R3 grant");
    cyc(0, win(0), 0, 0, "R11 quiet");

    cyc(1, win(2), REQ, 0, "R4 pend2");
    cyc(1, win(1), REQ, 0, "R4 pend1");
    cyc(1, win(3), REQ, 0, "R4 pend3");
    cyc(1, win(0), REQ, 0, "R4 self request");
    cyc(0, win(3), 0, 0, "R4 hold");

    cyc(1, win(3) | 16'h0018, REL, 0, "R2 offset");
    cyc(1, 16'h6000, SZ, 0, "R2 page6");
    cyc(0, 16'h6000, 0, 0, "R2 page6 read");
    cyc(1, 16'h8000 | win(3), 0, 0, "R2 alias high bit");

    cyc(1, win(4), REQ, 0, "R9 sw request");
    cyc(0, win(4), 0, 0, "R9 readback");

    cyc(1, win(1), REL, 0, "R7 withdraw");
    cyc(1, win(0), REL, 0, "R5 release");
    cyc(0, win(3), 0, 0, "R6 grant3");

    cyc(1, win(2), SZ, 0, "R8 low seize");
    cyc(1, win(3), SZ, 0, "R8 equal seize");
    cyc(1, win(4), SZ, 0, "R9 sw seize");
    cyc(1, win(4), SZ, 1, "R8 hw seize");
    cyc(1, win(4), REL, 0, "R9 sw release");
    cyc(1, win(4), REL, 1, "R5 hw release");
    cyc(0, win(2), 0, 0, "R6 grant2");

    cyc(1, win(0), REQ, 0, "R7 setup0");
    cyc(1, win(1), REQ, 0, "R7 setup1");
    cyc(1, win(2), REL, 0, "R5 free");
    cyc(1, win(1), REL, 0, "R7 withdraw at grant");
    cyc(0, win(0), 0, 0, "R7 after");

    cyc(1, win(0), REL | REQ, 0, "R8 precedence");
    cyc(1, win(2), SZ, 0, "R8 seize no owner");
    cyc(0, win(2), 0, 0, "R8 still free");

    for (int l = 0; l < 8; l++) cyc(0, win(l), 0, 0, "R10 sweep");

    lfsr = 32'h1ACE_B00C;
    for (int k = 0; k < 600; k++) begin
      logic [15:0] a;
      lfsr = lfsr * 1103515245 + 12345;
      a = win(int'(lfsr[18:16]) % 6);
      if (lfsr[23:21] == 3'd0) a = a | 16'h0024;
      cyc(lfsr[20], a, pat[int'(lfsr[29:26]) % 6], lfsr[24], "R6 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule